// File: doc/BRIEF.md
# I/O Port Access Permission Checker

This block decides whether a port I/O access of one, two or four bytes may proceed. It takes a start strobe together with the port number, the access width and the fields of the current task-state segment descriptor (base address, limit, present flag and 4-bit type). A check has up to two steps. First the descriptor is validated. Then two 16-bit words are fetched through a synchronous read port: the word that holds the offset of the permission bitmap, and the bitmap word that covers the port's bits. The checker finishes by pulsing `done` together with exactly one of `allow` or `fault`. A fault stands for a general-protection exception whose error code is always zero, so no separate code output is needed.

The memory port returns data one cycle after `memRdEn`, and it returns the byte at the requested address in bits 7:0 and the byte at the next address in bits 15:8. Because the bitmap word is always two bytes wide, an access whose bits run past the end of one byte is still tested in a single fetch. While a check is in progress, including its `done` cycle, any new start strobe is ignored.

Top module: `io_perm_checker`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `done`, `allow`, `fault` and `memRdEn` are all low.
- R2: A start is rejected with `done` and `fault` high in the cycle after the start edge, with no memory read, when any of these holds: the present flag is 0, the type is not 4'b1001, or the limit is below 103. A limit of exactly 103 passes this check.
- R3: For a descriptor that passes R2, `memRdEn` is high for one cycle in the cycle after the start edge, with `memRdAddr` equal to base + 0x66. The returned word is the bitmap offset, with the low byte at the lower address.
- R4: The byte index is the bitmap offset plus the port number shifted right by 3. In the cycle after the offset read, a second read is issued at base + byte index.
- R5: If byte index + 1 is greater than the limit, no second read is issued, and `done` and `fault` are high two cycles after the offset read. Byte index + 1 equal to the limit is within bounds.
- R6: The bitmap word is shifted right by the port's low 3 bits, and its low N bits are tested. N depends on the size code: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4. Any set bit gives `fault`, otherwise `allow`. The result appears with `done` two cycles after the bitmap read.
- R7: `done` is never high for two cycles in a row. When `done` is high, exactly one of `allow` and `fault` is high. When `done` is low, both are low.
- R8: A start strobe is ignored from the cycle a check is accepted up to and including its `done` cycle. A new check can be accepted in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| portAddr | input | 16 | Port number of the access |
| accSize | input | 2 | Access width code: 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| tssBase | input | 32 | Segment base byte address |
| tssLimit | input | 32 | Segment limit in bytes |
| tssPresent | input | 1 | Descriptor present flag |
| tssType | input | 4 | Descriptor type field |
| memRdEn | output | 1 | Read request to the 16-bit memory port |
| memRdAddr | output | 32 | Byte address of the read |
| memRdData | input | 16 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| allow | output | 1 | Access permitted (only with done) |
| fault | output | 1 | General-protection fault, error code 0 (only with done) |

## Verification
A wrong state in the sequencer shows at the ports within one cycle. A missing or extra `memRdEn`, a wrong read address, or a `done` pulse in the wrong cycle is visible at once, because the reference model predicts every port value on every clock. A wrong byte index or bit window shows up two cycles later as the wrong verdict, or one cycle later as a read at the wrong address. The patterns that expose these errors are bits that run past a byte boundary, the limit equal to and one below index + 1, and a two-byte offset whose high byte matters.

// File: rtl/iopc_pkg.sv
package iopc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OFS,
    ST_RD_BMP,
    ST_EVAL,
    ST_DONE
  } chkState_e;

  typedef struct packed {
    logic capture;
    logic issueOfs;
    logic issueBmp;
    logic judgeBits;
  } ctlStrobe_t;

  localparam logic [3:0]  TYPE_AVAIL32   = 4'b1001;
  localparam int unsigned MIN_SEG_LIMIT  = 103;
  localparam int unsigned OFS_FIELD_ADDR = 'h66;

  function automatic logic [3:0] sizeMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'b00:   sizeMask = 4'b0001;
      2'b01:   sizeMask = 4'b0011;
      default: sizeMask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/iopc_dpath.sv
module iopc_dpath
  import iopc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [PORT_W-1:0] portAddr,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] tssBase,
  input  logic [ADDR_W-1:0] tssLimit,
  input  logic              tssPresent,
  input  logic [3:0]        tssType,
  input  logic [WORD_W-1:0] memRdData,
  output logic              descOk,
  output logic              boundOk,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              verdictAllow
);

  localparam int SHIFT_W = PORT_W - 3;
  localparam int IDX_W   = ((SHIFT_W > WORD_W) ? SHIFT_W : WORD_W) + 1;
  localparam int CMP_W   = ADDR_W + 1;

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] limitQ;
  logic [PORT_W-1:0] portQ;
  logic [1:0]        sizeQ;
  logic              verdictQ;

  logic [IDX_W-1:0]  byteIdx;
  logic [CMP_W-1:0]  idxEnd;
  logic [3:0]        window;
  logic              bitsClear;

  // descriptor sanity is judged on the live inputs in the start cycle
  assign descOk = tssPresent && (tssType == TYPE_AVAIL32) &&
                  (tssLimit >= ADDR_W'(MIN_SEG_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
      portQ  <= '0;
      sizeQ  <= '0;
    end else if (strobe.capture) begin
      baseQ  <= tssBase;
      limitQ <= tssLimit;
      portQ  <= portAddr;
      sizeQ  <= accSize;
    end
  end

  // offset word arrives on memRdData during the bitmap-issue cycle
  always_comb begin
    byteIdx = IDX_W'(memRdData) + IDX_W'(portQ[PORT_W-1:3]);
    idxEnd  = CMP_W'(byteIdx) + CMP_W'(1);
    boundOk = idxEnd <= {1'b0, limitQ};
  end

  always_comb begin
    if (strobe.issueOfs) memRdAddr = baseQ + ADDR_W'(OFS_FIELD_ADDR);
    else                 memRdAddr = baseQ + ADDR_W'(byteIdx);
  end

  // bitmap word arrives during the evaluation cycle
  always_comb begin
    window    = 4'(memRdData >> portQ[2:0]);
    bitsClear = (window & sizeMask(sizeQ)) == 4'b0000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 verdictQ <= 1'b0;
    else if (strobe.capture)   verdictQ <= 1'b0;
    else if (strobe.judgeBits) verdictQ <= bitsClear;
  end

  assign verdictAllow = verdictQ;

  // R6: a set bit inside the tested window can never lead to a permit
  a_r6_set_bit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.judgeBits && !bitsClear) |=> !verdictAllow);

  // R8: captured access fields stay put while no capture is requested
  a_r8_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(portQ) && $stable(sizeQ) && $stable(baseQ));

endmodule

// File: rtl/iopc_ctrl.sv
module iopc_ctrl
  import iopc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       descOk,
  input  logic       boundOk,
  output ctlStrobe_t strobe,
  output logic       memRdEn,
  output logic       done,
  output logic       ready
);

  chkState_e stQ, stD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  always_comb begin
    stD     = stQ;
    strobe  = '0;
    memRdEn = 1'b0;
    done    = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stD = descOk ? ST_RD_OFS : ST_DONE;
        end
      end
      ST_RD_OFS: begin
        strobe.issueOfs = 1'b1;
        memRdEn = 1'b1;
        stD = ST_RD_BMP;
      end
      ST_RD_BMP: begin
        if (boundOk) begin
          strobe.issueBmp = 1'b1;
          memRdEn = 1'b1;
          stD = ST_EVAL;
        end else begin
          stD = ST_DONE;
        end
      end
      ST_EVAL: begin
        strobe.judgeBits = 1'b1;
        stD = ST_DONE;
      end
      ST_DONE: begin
        done = 1'b1;
        stD = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  assign ready = (stQ == ST_IDLE);

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: an out-of-bounds index ends the check with no second read
  a_r5_bound_stop: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_RD_BMP && !boundOk) |-> !memRdEn ##1 done);

  // R8: a start seen during the done cycle does not launch a read
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !memRdEn);

  // R3: reads never overlap the completion pulse
  a_r3_read_not_done: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !done);

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
  import iopc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PORT_W-1:0] portAddr,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] tssBase,
  input  logic [ADDR_W-1:0] tssLimit,
  input  logic              tssPresent,
  input  logic [3:0]        tssType,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              done,
  output logic              allow,
  output logic              fault
);

  ctlStrobe_t strobe;
  logic descOk;
  logic boundOk;
  logic verdictAllow;
  logic ready;

  iopc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .descOk  (descOk),
    .boundOk (boundOk),
    .strobe  (strobe),
    .memRdEn (memRdEn),
    .done    (done),
    .ready   (ready)
  );

  iopc_dpath #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W),
    .WORD_W (WORD_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .portAddr     (portAddr),
    .accSize      (accSize),
    .tssBase      (tssBase),
    .tssLimit     (tssLimit),
    .tssPresent   (tssPresent),
    .tssType      (tssType),
    .memRdData    (memRdData),
    .descOk       (descOk),
    .boundOk      (boundOk),
    .memRdAddr    (memRdAddr),
    .verdictAllow (verdictAllow)
  );

  assign allow = done &&  verdictAllow;
  assign fault = done && !verdictAllow;

  // R7: verdict outputs are exclusive and only present with done
  a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (allow != fault));

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(allow || fault));

  // R2: a bad descriptor at an accepted start faults on the next cycle
  a_r2_desc_fault: assert property (@(posedge clk) disable iff (!rstN)
    (ready && start && !descOk) |=> (fault && !memRdEn));

endmodule

// File: tb/io_perm_checker_tb_top.sv
`timescale 1ns/1ps
module io_perm_checker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] portAddr = '0;
  logic [1:0]  accSize = '0;
  logic [31:0] tssBase = '0;
  logic [31:0] tssLimit = '0;
  logic        tssPresent = 1'b0;
  logic [3:0]  tssType = '0;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic [15:0] memRdData = '0;
  logic        done, allow, fault;

  always #5 clk = ~clk;

  io_perm_checker dut_i (
    .clk(clk), .rstN(rstN), .start(start), .portAddr(portAddr),
    .accSize(accSize), .tssBase(tssBase), .tssLimit(tssLimit),
    .tssPresent(tssPresent), .tssType(tssType), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .done(done),
    .allow(allow), .fault(fault)
  );

  // byte-addressed memory behind a one-cycle 16-bit read port
  logic [7:0] mem [int unsigned];

  function automatic logic [7:0] rdByte(input int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk)
    if (memRdEn) memRdData <= {rdByte(memRdAddr + 1), rdByte(memRdAddr)};

  task automatic putWord(input int unsigned a, input logic [15:0] w);
    mem[a]     = w[7:0];
    mem[a + 1] = w[15:8];
  endtask

  // reference model: one expected port snapshot per cycle
  typedef struct {
    bit          rdEn;
    int unsigned addr;
    bit          dn;
    bit          al;
    bit          fl;
    string       tag;
  } expCycle_t;

  expCycle_t expQ[$];
  string forceTag = "";
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic expCycle_t mk(bit r, int unsigned a, bit d, bit al, bit fl, string t);
    expCycle_t e;
    e.rdEn = r; e.addr = a; e.dn = d; e.al = al; e.fl = fl;
    e.tag = (forceTag != "") ? forceTag : t;
    return e;
  endfunction

  task automatic planCheck();
    int unsigned ofs, idx, word, win, n;
    bit ok;
    if (!tssPresent || tssType != 4'd9 || tssLimit < 103) begin
      expQ.push_back(mk(0, 0, 1, 0, 1, "R2"));
    end else begin
      expQ.push_back(mk(1, tssBase + 'h66, 0, 0, 0, "R3"));
      ofs = {24'h0, rdByte(tssBase + 'h66)} | ({24'h0, rdByte(tssBase + 'h67)} << 8);
      idx = ofs + (portAddr >> 3);
      if (64'(idx) + 1 > 64'(tssLimit)) begin
        expQ.push_back(mk(0, 0, 0, 0, 0, "R5"));
        expQ.push_back(mk(0, 0, 1, 0, 1, "R5"));
      end else begin
        expQ.push_back(mk(1, tssBase + idx, 0, 0, 0, "R4"));
        expQ.push_back(mk(0, 0, 0, 0, 0, "R6"));
        word = {24'h0, rdByte(tssBase + idx)} | ({24'h0, rdByte(tssBase + idx + 1)} << 8);
        n = (accSize == 2'b00) ? 1 : (accSize == 2'b01) ? 2 : 4;
        win = (word >> portAddr[2:0]) & ((1 << n) - 1);
        ok = (win == 0);
        expQ.push_back(mk(0, 0, 1, ok, !ok, "R6 R7"));
      end
    end
    expQ.push_back(mk(0, 0, 0, 0, 0, "R8"));
  endtask

  always @(posedge clk)
    if (rstN && start && expQ.size() == 0) planCheck();

  always @(negedge clk) begin
    expCycle_t e;
    bit bad;
    if (rstN && !finished) begin
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = mk(0, 0, 0, 0, 0, "R7");
      bad = (memRdEn !== e.rdEn) || (done !== e.dn) || (allow !== e.al) ||
            (fault !== e.fl) || (e.rdEn && memRdAddr !== e.addr);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s t=%0t: rdEn=%0b addr=%h done=%0b allow=%0b fault=%0b expected rdEn=%0b addr=%h done=%0b allow=%0b fault=%0b",
                 e.tag, $time, memRdEn, memRdAddr, done, allow, fault,
                 e.rdEn, e.addr, e.dn, e.al, e.fl);
      end
    end
  end

  task automatic runCheck(input logic [15:0] p, input logic [1:0] sz,
                          input logic [31:0] b, input logic [31:0] lim,
                          input bit pres, input logic [3:0] ty);
    @(negedge clk);
    portAddr = p; accSize = sz; tssBase = b; tssLimit = lim;
    tssPresent = pres; tssType = ty; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish();
  end

  initial begin
    // base 0x1000, bitmap offset 0x0068 -> bitmap at 0x1068
    putWord(32'h1066, 16'h0068);
    mem[32'h106C] = 8'h08;          // port 0x23 blocked
    mem[32'h106E] = 8'h01;          // port 0x30 blocked
    putWord(32'h2066, 16'h0010);    // base 0x2000, tight limit test
    putWord(32'h3066, 16'h1234);    // high byte of offset matters
    mem[32'h4234] = 8'h01;
    for (int i = 0; i < 64; i++) mem[32'h10A8 + i] = 8'($urandom);

    // R1: outputs quiet while in reset
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 0 || allow !== 0 || fault !== 0 || memRdEn !== 0) begin
      fails++;
      $display("FAIL R1: done=%0b allow=%0b fault=%0b rdEn=%0b expected all 0",
               done, allow, fault, memRdEn);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: descriptor rejects and the limit boundary
    runCheck(16'h0020, 2'b00, 32'h1000, 32'h2067, 1'b0, 4'd9);
    runCheck(16'h0020, 2'b00, 32'h1000, 32'h2067, 1'b1, 4'hB);
    runCheck(16'h0000, 2'b00, 32'h2000, 32'd102,  1'b1, 4'd9);
    runCheck(16'h0000, 2'b00, 32'h2000, 32'd103,  1'b1, 4'd9);

    // R6: bit test by size, including a window crossing a byte edge
    runCheck(16'h0023, 2'b00, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h0020, 2'b01, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h0020, 2'b10, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h002F, 2'b00, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h002F, 2'b01, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h002D, 2'b11, 32'h1000, 32'h2067, 1'b1, 4'd9);
    runCheck(16'h002C, 2'b11, 32'h1000, 32'h2067, 1'b1, 4'd9);

    // R3 R4: two-byte offset with nonzero high byte
    runCheck(16'h0000, 2'b00, 32'h3000, 32'h0000FFFF, 1'b1, 4'd9);
    runCheck(16'h0008, 2'b00, 32'h3000, 32'h0000FFFF, 1'b1, 4'd9);

    // R5: index+1 equal to limit passes, one more faults
    runCheck(16'h0100, 2'b00, 32'h1000, 32'h89, 1'b1, 4'd9);
    runCheck(16'h0100, 2'b00, 32'h1000, 32'h88, 1'b1, 4'd9);

    // R8: start held high through a check is ignored until idle
    forceTag = "R8";
    @(negedge clk);
    portAddr = 16'h0023; accSize = 2'b00; tssBase = 32'h1000;
    tssLimit = 32'h2067; tssPresent = 1'b1; tssType = 4'd9; start = 1'b1;
    @(negedge clk);
    portAddr = 16'h0020;
    repeat (4) @(negedge clk);
    start = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    forceTag = "";

    // R6: scattered ports over random bitmap bytes
    for (int k = 0; k < 24; k++)
      runCheck(16'h0200 + 16'($urandom_range(0, 16'h1F7)), 2'($urandom),
               32'h1000, 32'h2067, 1'b1, 4'd9);

    repeat (3) @(negedge clk);
    finish();
  end

endmodule